// File: doc/BRIEF.md
# Paged NIC Host Register Bank

This block is the register bank that a host processor sees on a legacy Ethernet controller. The host reaches it through a byte-wide port with a 4-bit offset. Offset 0 always holds the command register. The top two bits of that register choose one of four pages, and the other fifteen offsets are decoded against the chosen page. The bank holds the following state:

- the receive ring page limits and the boundary and current-page pointers;
- the transmit start page and the 16-bit transmit length;
- the remote DMA start address and byte count;
- the receive configuration and the data configuration bytes;
- the interrupt mask;
- six station address bytes and eight multicast hash bytes.

The interrupt status register collects event flags, and the block drives one level-sensitive interrupt from it. A command write that requests a transmit produces a one-cycle start pulse. The pulse carries the byte address and the length for the frame serialiser downstream. That pulse is dropped when the frame would run past the end of packet memory. The completion status is still posted in that case.

Reads are combinational from the current offset and the current page. Writes take effect on the rising clock edge while `wr_en_i` is high.

Top module: `nic_regbank`

## Requirements
- R1: The page is the value of command bits 7:6. The register index is `{page, offset}`. Offset 0 reads and writes the command register on every page. Page 1 offsets 1..6 hold the station bytes and offsets 8..15 hold the hash bytes. Page 0 offset 12 drives `rx_cfg_o` and page 0 offset 14 drives `dma_cfg_o`.
- R2: A write to page 0 offset 7 clears each of status bits 6:0 for which the written byte has a 1. Status bit 7 (reset done) is never changed by such a write.
- R3: `irq_o` is high exactly when some bit in 6:0 of (status AND mask) is set. The mask is written at page 0 offset 15. Status bit 7 never raises the interrupt.
- R4: After reset the status reads 0x80, the command reads 0x21 and `irq_o` is low.
- R5: A command write with bit 0 (stop) clear clears status bit 7.
- R6: A command write has bit 0 clear and bit 3 or bit 4 set, and the remote count (page 0 offsets 10/11) is zero at that time. That write sets status bit 6 in the same cycle. A nonzero count leaves bit 6 unchanged.
- R7: A command write with bit 0 clear and bit 2 set does four things. It raises `tx_start_o` for one cycle after the write edge, with `tx_addr_o` = transmit page (page 0 offset 4) << 8 and `tx_len_o` = transmit count (page 0 offsets 5/6). It sets the transmit status (page 0 offset 4 read) to 0x01. It sets status bit 1. It stores the command with bit 2 cleared.
- R8: The start pulse is suppressed when `tx_addr_o + tx_len_o` would exceed `PMEM_END`. Status bit 1 and the transmit status are still set.
- R9: Ring start (page 0 offset 1) and stop (page 0 offset 2) are written only when value<<8 <= `PMEM_END`. Boundary (page 0 offset 3) and current page (page 1 offset 7) are written only when value<<8 < `PMEM_END`. Start and stop read back on page 2 offsets 1 and 2.
- R10: On page 0, offsets 10 and 11 read 0x50 and 0x43. On page 3, offset 3 reads 0x00 and offsets 5 and 6 read 0x40.
- R11: Each 16-bit register (transmit count, remote start at page 0 offsets 8/9, remote count) is written one byte at a time. A write to one byte leaves the other byte unchanged.
- R12: Indices that are not mapped read 0x00, and writes to them change nothing.
- R13: A command write with bit 0 set is stored as written. It launches nothing and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current offset and page |
| irq_o | output | 1 | Level interrupt |
| rx_cfg_o | output | 8 | Receive configuration byte |
| dma_cfg_o | output | 8 | Data configuration byte |
| tx_start_o | output | 1 | One-cycle transmit launch pulse |
| tx_addr_o | output | 16 | Frame start byte address |
| tx_len_o | output | 16 | Frame length in bytes |

## Verification
The command register can post several status events in a single write. One byte can carry a transmit request and a remote-write request while the remote count is zero. That write must set status bits 1 and 6 together, clear bit 7, and emit the start pulse, all in the same cycle. The bench sets the count to zero and the mask to the transmit bit, then issues command 0x16. The scoreboard expects status 0x42, a command readback of 0x12, a raised interrupt, and exactly one queued launch record that matches the pulse.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
  // command bits
  localparam int CB_STOP = 0;
  localparam int CB_XMIT = 2;
  localparam int CB_RRD  = 3;
  localparam int CB_RWR  = 4;
  // status bits
  localparam int SB_TXOK = 1;
  localparam int SB_DMA  = 6;
  localparam int SB_RST  = 7;

  localparam logic [7:0] CMD_RST_VAL = 8'h21;
  localparam logic [7:0] STS_RST_VAL = 8'h80;
  localparam logic [7:0] ID_BYTE_A   = 8'h50;
  localparam logic [7:0] ID_BYTE_B   = 8'h43;
  localparam logic [7:0] LINK_BYTE   = 8'h40;

  typedef logic [5:0] ridx_t;
  // page 0
  localparam ridx_t IX_RSTART = 6'h01;
  localparam ridx_t IX_RSTOP  = 6'h02;
  localparam ridx_t IX_BNDRY  = 6'h03;
  localparam ridx_t IX_TXPG   = 6'h04;
  localparam ridx_t IX_TXLO   = 6'h05;
  localparam ridx_t IX_TXHI   = 6'h06;
  localparam ridx_t IX_STS    = 6'h07;
  localparam ridx_t IX_DALO   = 6'h08;
  localparam ridx_t IX_DAHI   = 6'h09;
  localparam ridx_t IX_DCLO   = 6'h0A;
  localparam ridx_t IX_DCHI   = 6'h0B;
  localparam ridx_t IX_RXCFG  = 6'h0C;
  localparam ridx_t IX_DCFG   = 6'h0E;
  localparam ridx_t IX_MASK   = 6'h0F;
  // page 1
  localparam ridx_t IX_CURPG  = 6'h17;
  // page 2
  localparam ridx_t IX_RDSTRT = 6'h21;
  localparam ridx_t IX_RDSTOP = 6'h22;
  // page 3
  localparam ridx_t IX_CFG0   = 6'h33;
  localparam ridx_t IX_CFG2   = 6'h35;
  localparam ridx_t IX_CFG3   = 6'h36;
endpackage

// File: rtl/nic_status.sv
module nic_status
  import nic_regbank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_go_i,
  input  logic [7:0] cmd_val_i,
  input  logic       dcnt_zero_i,
  input  logic       clr_we_i,
  input  logic [7:0] clr_val_i,
  input  logic [7:0] mask_i,
  output logic [7:0] sts_o,
  output logic       irq_o
);
  logic [7:0] sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (clr_we_i) sts_d[6:0] = sts_d[6:0] & ~clr_val_i[6:0];
    if (cmd_go_i) begin
      sts_d[SB_RST] = 1'b0;
      if ((cmd_val_i[CB_RRD] | cmd_val_i[CB_RWR]) && dcnt_zero_i) sts_d[SB_DMA] = 1'b1;
      if (cmd_val_i[CB_XMIT]) sts_d[SB_TXOK] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= STS_RST_VAL;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q[6:0] & mask_i[6:0]);

  a_r2_rst_bit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !cmd_go_i) |=> (sts_q[SB_RST] == $past(sts_q[SB_RST])));
  a_r5_rst_bit_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go_i |=> !sts_q[SB_RST]);
  a_r6_dma_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go_i && (cmd_val_i[CB_RRD] || cmd_val_i[CB_RWR]) && dcnt_zero_i) |=> sts_q[SB_DMA]);
  a_r3_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_i[6:0] != 7'd0));
endmodule

// File: rtl/nic_tx_launch.sv
module nic_tx_launch #(
  parameter int AW       = 16,
  parameter int PMEM_END = 'hC000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [7:0]    page_i,
  input  logic [AW-1:0] len_i,
  output logic          tx_start_o,
  output logic [AW-1:0] tx_addr_o,
  output logic [AW-1:0] tx_len_o
);
  localparam logic [AW:0] END_W = (AW+1)'(PMEM_END);

  logic [AW-1:0] base;
  logic [AW:0]   last;
  logic          fits;

  assign base = AW'({page_i, 8'h00});
  assign last = {1'b0, base} + {1'b0, len_i};
  assign fits = (last <= END_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_start_o <= 1'b0;
      tx_addr_o  <= '0;
      tx_len_o   <= '0;
    end else begin
      tx_start_o <= go_i && fits;
      if (go_i) begin
        tx_addr_o <= base;
        tx_len_o  <= len_i;
      end
    end
  end

  a_r7_pulse_follows_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(go_i));
  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (({1'b0, tx_addr_o} + {1'b0, tx_len_o}) <= END_W));
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PMEM_END  = 'hC000,
  parameter int N_STATION = 6,
  parameter int N_HASH    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          irq_o,
  output logic [7:0]    rx_cfg_o,
  output logic [7:0]    dma_cfg_o,
  output logic          tx_start_o,
  output logic [AW-1:0] tx_addr_o,
  output logic [AW-1:0] tx_len_o
);
  localparam logic [16:0] END_W  = 17'(PMEM_END);
  localparam int          ST_LO  = 1;
  localparam int          HS_LO  = 8;

  logic [7:0]  cmd_q, tsr_q, mask_q, rxcfg_q, dcfg_q;
  logic [7:0]  pstart_q, pstop_q, bndry_q, curpg_q, txpg_q;
  logic [15:0] txcnt_q, dadr_q, dcnt_q;
  logic [7:0]  station_q [N_STATION];
  logic [7:0]  hash_q    [N_HASH];
  logic [7:0]  sts;

  ridx_t idx;
  logic  cmd_we, cmd_go, reg_we, pg_le, pg_lt;

  assign idx    = {cmd_q[7:6], addr_i};
  assign cmd_we = wr_en_i && (addr_i == 4'd0);
  assign cmd_go = cmd_we && !wdata_i[CB_STOP];
  assign reg_we = wr_en_i && (addr_i != 4'd0);
  assign pg_le  = ({1'b0, wdata_i, 8'h00} <= END_W);
  assign pg_lt  = ({1'b0, wdata_i, 8'h00} <  END_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= CMD_RST_VAL;
      tsr_q    <= '0;
      mask_q   <= '0;
      rxcfg_q  <= '0;
      dcfg_q   <= '0;
      pstart_q <= '0;
      pstop_q  <= '0;
      bndry_q  <= '0;
      curpg_q  <= '0;
      txpg_q   <= '0;
      txcnt_q  <= '0;
      dadr_q   <= '0;
      dcnt_q   <= '0;
    end else begin
      if (cmd_we) begin
        cmd_q <= wdata_i;
        if (cmd_go && wdata_i[CB_XMIT]) begin
          cmd_q[CB_XMIT] <= 1'b0;
          tsr_q          <= 8'h01;
        end
      end
      if (reg_we) begin
        unique case (idx)
          IX_RSTART: if (pg_le) pstart_q <= wdata_i;
          IX_RSTOP:  if (pg_le) pstop_q  <= wdata_i;
          IX_BNDRY:  if (pg_lt) bndry_q  <= wdata_i;
          IX_CURPG:  if (pg_lt) curpg_q  <= wdata_i;
          IX_TXPG:   txpg_q        <= wdata_i;
          IX_TXLO:   txcnt_q[7:0]  <= wdata_i;
          IX_TXHI:   txcnt_q[15:8] <= wdata_i;
          IX_DALO:   dadr_q[7:0]   <= wdata_i;
          IX_DAHI:   dadr_q[15:8]  <= wdata_i;
          IX_DCLO:   dcnt_q[7:0]   <= wdata_i;
          IX_DCHI:   dcnt_q[15:8]  <= wdata_i;
          IX_RXCFG:  rxcfg_q       <= wdata_i;
          IX_DCFG:   dcfg_q        <= wdata_i;
          IX_MASK:   mask_q        <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  // page 1 address bytes
  for (genvar g = 0; g < N_STATION; g++) begin : g_station
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) station_q[g] <= '0;
      else if (reg_we && idx == ridx_t'(6'h10 + ST_LO + g)) station_q[g] <= wdata_i;
    end
  end
  for (genvar g = 0; g < N_HASH; g++) begin : g_hash
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hash_q[g] <= '0;
      else if (reg_we && idx == ridx_t'(6'h10 + HS_LO + g)) hash_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == 4'd0) begin
      rdata_o = cmd_q;
    end else begin
      unique case (idx)
        IX_BNDRY:  rdata_o = bndry_q;
        IX_TXPG:   rdata_o = tsr_q;
        IX_STS:    rdata_o = sts;
        IX_DALO:   rdata_o = dadr_q[7:0];
        IX_DAHI:   rdata_o = dadr_q[15:8];
        IX_DCLO:   rdata_o = ID_BYTE_A;
        IX_DCHI:   rdata_o = ID_BYTE_B;
        IX_CURPG:  rdata_o = curpg_q;
        IX_RDSTRT: rdata_o = pstart_q;
        IX_RDSTOP: rdata_o = pstop_q;
        IX_CFG0:   rdata_o = 8'h00;
        IX_CFG2:   rdata_o = LINK_BYTE;
        IX_CFG3:   rdata_o = LINK_BYTE;
        default: begin
          for (int k = 0; k < N_STATION; k++)
            if (idx == ridx_t'(6'h10 + ST_LO + k)) rdata_o = station_q[k];
          for (int k = 0; k < N_HASH; k++)
            if (idx == ridx_t'(6'h10 + HS_LO + k)) rdata_o = hash_q[k];
        end
      endcase
    end
  end

  assign rx_cfg_o  = rxcfg_q;
  assign dma_cfg_o = dcfg_q;

  nic_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_go_i    (cmd_go),
    .cmd_val_i   (wdata_i),
    .dcnt_zero_i (dcnt_q == 16'd0),
    .clr_we_i    (reg_we && idx == IX_STS),
    .clr_val_i   (wdata_i),
    .mask_i      (mask_q),
    .sts_o       (sts),
    .irq_o       (irq_o)
  );

  nic_tx_launch #(.AW(AW), .PMEM_END(PMEM_END)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (cmd_go && wdata_i[CB_XMIT]),
    .page_i     (txpg_q),
    .len_i      (AW'(txcnt_q)),
    .tx_start_o (tx_start_o),
    .tx_addr_o  (tx_addr_o),
    .tx_len_o   (tx_len_o)
  );

  a_r9_bndry_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, bndry_q, 8'h00} < END_W));
  a_r9_curpg_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, curpg_q, 8'h00} < END_W));
  a_r7_cmd_xmit_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go && wdata_i[CB_XMIT] |=> !cmd_q[CB_XMIT]);
endmodule

// File: tb/nic_regbank_tb_top.sv
`timescale 1ns/1ps
module nic_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq, tx_start;
  logic [7:0]  rx_cfg, dma_cfg;
  logic [15:0] tx_addr, tx_len;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nic_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rx_cfg_o(rx_cfg), .dma_cfg_o(dma_cfg),
    .tx_start_o(tx_start), .tx_addr_o(tx_addr), .tx_len_o(tx_len)
  );

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  typedef struct { logic [15:0] a; logic [15:0] l; string tag; } tx_t;
  item_t exq[$];
  tx_t   txq[$];

  // driver
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic exp_rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; exq.push_back('{0, e, t});
  endtask
  task automatic exp_out(input int k, input logic [7:0] e, input string t);
    @(negedge clk); exq.push_back('{k, e, t});
  endtask
  task automatic exp_tx(input logic [15:0] a, input logic [15:0] l, input string t);
    txq.push_back('{a, l, t});
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    while (exq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = exq.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {7'd0, irq};
        2: act = rx_cfg;
        default: act = dma_cfg;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
      end
    end
    if (rst_n && tx_start) begin
      checks++;
      if (txq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected launch actual=%04h/%04h expected=none", tx_addr, tx_len);
      end else begin
        tx_t tt;
        tt = txq.pop_front();
        if (tx_addr !== tt.a || tx_len !== tt.l) begin
          errors++;
          $display("FAIL %s launch actual=%04h/%04h expected=%04h/%04h",
                   tt.tag, tx_addr, tx_len, tt.a, tt.l);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    exp_rd(4'h0, 8'h21, "R4"); exp_rd(4'h7, 8'h80, "R4"); exp_out(1, 8'h00, "R4");
    // R2 / R3: reset-done bit survives clear and never interrupts
    wr(4'hF, 8'hFF); wr(4'h7, 8'hFF);
    exp_rd(4'h7, 8'h80, "R2"); exp_out(1, 8'h00, "R3");
    wr(4'hF, 8'h00);
    // R13 stop set: stored, no launch, status unchanged
    wr(4'h0, 8'h25);
    exp_rd(4'h0, 8'h25, "R13"); exp_rd(4'h7, 8'h80, "R13");
    // R5
    wr(4'h0, 8'h22);
    exp_rd(4'h7, 8'h00, "R5"); exp_rd(4'h0, 8'h22, "R5");
    // R10 / R12 / R1 config
    exp_rd(4'hA, 8'h50, "R10"); exp_rd(4'hB, 8'h43, "R10");
    wr(4'hD, 8'hFF); exp_rd(4'hD, 8'h00, "R12");
    wr(4'hC, 8'h0C); exp_out(2, 8'h0C, "R1");
    wr(4'hE, 8'h49); exp_out(3, 8'h49, "R1");
    // R11 split bytes
    wr(4'h8, 8'h34); wr(4'h9, 8'h12);
    exp_rd(4'h8, 8'h34, "R11"); exp_rd(4'h9, 8'h12, "R11");
    wr(4'h8, 8'h78);
    exp_rd(4'h9, 8'h12, "R11"); exp_rd(4'h8, 8'h78, "R11");
    // R6 zero count remote read
    wr(4'h0, 8'h0A);
    exp_rd(4'h7, 8'h40, "R6"); exp_out(1, 8'h00, "R3");
    wr(4'hF, 8'h40); exp_out(1, 8'h01, "R3");
    wr(4'h7, 8'h40);
    exp_rd(4'h7, 8'h00, "R2"); exp_out(1, 8'h00, "R2");
    wr(4'hA, 8'h05); wr(4'h0, 8'h0A);
    exp_rd(4'h7, 8'h00, "R6");
    wr(4'h0, 8'h22);
    // R7 launch
    wr(4'h4, 8'h40); wr(4'h6, 8'h05); wr(4'h5, 8'hEA);
    exp_tx(16'h4000, 16'h05EA, "R7"); wr(4'h0, 8'h26);
    exp_rd(4'h0, 8'h22, "R7"); exp_rd(4'h4, 8'h01, "R7"); exp_rd(4'h7, 8'h02, "R7");
    wr(4'h5, 8'h00);
    exp_tx(16'h4000, 16'h0500, "R11"); wr(4'h0, 8'h26);
    wr(4'h7, 8'hFF);
    // R8 end-of-memory bound
    wr(4'h4, 8'hBF); wr(4'h6, 8'h01); wr(4'h5, 8'h00);
    exp_tx(16'hBF00, 16'h0100, "R8"); wr(4'h0, 8'h26);
    wr(4'h7, 8'hFF);
    wr(4'h5, 8'h01); wr(4'h0, 8'h26);
    exp_rd(4'h7, 8'h02, "R8");
    wr(4'h7, 8'hFF);
    // combined: transmit + zero-count remote write in one command
    wr(4'hA, 8'h00); wr(4'hF, 8'h02); wr(4'h5, 8'h00);
    exp_tx(16'hBF00, 16'h0100, "R7"); wr(4'h0, 8'h16);
    exp_rd(4'h7, 8'h42, "R6"); exp_rd(4'h0, 8'h12, "R7"); exp_out(1, 8'h01, "R3");
    wr(4'h7, 8'hFF); wr(4'hF, 8'h00);
    wr(4'h0, 8'h22);
    // R9 page limits
    wr(4'h1, 8'hC0); wr(4'h1, 8'hC1); wr(4'h2, 8'h80);
    wr(4'h3, 8'hC0); exp_rd(4'h3, 8'h00, "R9");
    wr(4'h3, 8'hBF); exp_rd(4'h3, 8'hBF, "R9");
    wr(4'h0, 8'hA2);
    exp_rd(4'h1, 8'hC0, "R9"); exp_rd(4'h2, 8'h80, "R9");
    wr(4'h1, 8'h11); exp_rd(4'h1, 8'hC0, "R12");
    // R1 page 1
    wr(4'h0, 8'h62);
    for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h10 + i));
    for (int i = 8; i <= 15; i++) wr(4'(i), 8'(8'hA0 + i));
    wr(4'h7, 8'hC0); exp_rd(4'h7, 8'h00, "R9");
    wr(4'h7, 8'hBF); exp_rd(4'h7, 8'hBF, "R9");
    for (int i = 1; i <= 6; i++) exp_rd(4'(i), 8'(8'h10 + i), "R1");
    for (int i = 8; i <= 15; i++) exp_rd(4'(i), 8'(8'hA0 + i), "R1");
    exp_rd(4'h0, 8'h62, "R1");
    wr(4'h0, 8'h22);
    exp_rd(4'h1, 8'h00, "R1"); exp_rd(4'h7, 8'h00, "R1");
    // R10 page 3
    wr(4'h0, 8'hE2);
    exp_rd(4'h3, 8'h00, "R10"); exp_rd(4'h5, 8'h40, "R10");
    exp_rd(4'h6, 8'h40, "R10"); exp_rd(4'h4, 8'h00, "R12"); exp_rd(4'hF, 8'h00, "R12");

    repeat (4) @(negedge clk);
    #3;
    while (txq.size() > 0) begin
      tx_t tt;
      tt = txq.pop_front();
      checks++; errors++;
      $display("FAIL %s launch actual=none expected=%04h/%04h", tt.tag, tt.a, tt.l);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule